// File: doc/BRIEF.md
# Dual-Bank Access Stall Controller

This block sits in the issue stage of a processor that can make one data-side and one program-side memory access in the same instruction. The internal memory has two blocks, and each address generator can reach either one. For every instruction the controller reads the selected index register of each generator and uses it, unmodified, as that access's address. It then adds the selected modify register to the index register. One address bit decides which block each access hits.

If the two accesses fall in different blocks, or only one access is requested, both go out in the same cycle and the instruction is accepted at once. If both land in the same block, the controller splits them. The data-side access goes first while the pipeline is held for one cycle, and the program-side access follows in the next cycle. A second kind of stall covers a load from memory into one of the program-side generator's index registers. The next instruction that addresses through that generator is held for one bubble cycle. Any cycle in between that does not use the program-side generator absorbs the bubble.

Register loads travel with the instruction that performs them. They are written when that instruction is accepted.

Top module: `dual_bank_stall_ctl`

## Requirements
- R1: The block of an access is bit BLK_BIT (17 by default) of its 24-bit address. A 0 in that bit means block 0 and a 1 means block 1. Two addresses on either side of 0x20000 therefore fall in different blocks.
- R2: An instruction whose enabled accesses target different blocks, or which has at most one access enabled, raises every requested go strobe and in_ready in the same cycle, with stall low.
- R3: An instruction with both accesses enabled that target the same block behaves as follows. In the first cycle only dm_go is raised, with stall high and in_ready low. In the next cycle only pm_go is raised, with stall low and in_ready high. The instruction thus takes exactly two cycles.
- R4: Each access presents the current value of its selected index register. That register then becomes index plus modify, modulo 2^24. This update happens exactly once, on the clock edge of the cycle in which that access's go strobe is high.
- R5: An access slot whose enable is low raises no go strobe, takes no part in the collision test and leaves its index register unchanged.
- R6: Suppose an accepted instruction loads a program-side index register (ld_en=1, ld_gen=1, ld_mod=0). If the next cycle presents an instruction with pm_en=1, that cycle has stall high, in_ready low and no go strobe. The instruction is then handled normally in the following cycle.
- R7: The delay in R6 does not arise if any cycle without such an instruction comes between the two. That includes an idle cycle, an instruction that does not use the program side, and a load into a data-side register or into a modify register.
- R8: Loads take effect on the edge at which the instruction is accepted. ld_gen selects the generator (0 data side, 1 program side) and ld_mod selects the register kind (0 index, 1 modify). When a load and a post-modify hit the same register on one edge, the loaded value wins.
- R9: During reset, and after it until the first issue, all index and modify registers read zero and stall, dm_go, pm_go and in_ready are low.
- R10: A cycle with in_valid low, outside the second half of a split, raises no go strobe and no stall, and keeps in_ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented |
| in_ready | output | 1 | The presented instruction completes this cycle |
| dm_en | input | 1 | The instruction makes a data-side access |
| dm_isel | input | 3 | Data-side index register number |
| dm_msel | input | 3 | Data-side modify register number |
| pm_en | input | 1 | The instruction makes a program-side access |
| pm_isel | input | 3 | Program-side index register number |
| pm_msel | input | 3 | Program-side modify register number |
| ld_en | input | 1 | The instruction loads a generator register |
| ld_gen | input | 1 | Load target generator: 0 data side, 1 program side |
| ld_mod | input | 1 | Load target kind: 0 index, 1 modify |
| ld_sel | input | 3 | Load target register number |
| ld_val | input | 24 | Value loaded |
| dm_go | output | 1 | The data-side access is performed this cycle |
| dm_addr | output | 24 | Data-side access address |
| pm_go | output | 1 | The program-side access is performed this cycle |
| pm_addr | output | 24 | Program-side access address |
| stall | output | 1 | The pipeline is held for this cycle |

## Verification
The assertions assume that an instruction stays on the inputs, with in_valid high and every field unchanged, until the cycle in which in_ready is high. The second cycle of a split and the bubble after a program-side index load both rely on that. The bench keeps to this by changing inputs only after an observed acceptance, one half period after the clock edge. Idle cycles are placed only between instructions. Random runs mix collisions, index loads followed directly by program-side use, and disabled slots that point into the busy block.

// File: rtl/asc_pkg.sv
package asc_pkg;
   typedef enum logic {
      PH_MAIN   = 1'b0,
      PH_SECOND = 1'b1
   } asc_phase_e;
endpackage

// File: rtl/asc_addr_gen.sv
module asc_addr_gen #(
   parameter int AW   = 24,
   parameter int NREG = 8,
   parameter int SELW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [SELW-1:0] isel,
   input  logic [SELW-1:0] msel,
   input  logic            commit,
   input  logic            ld_idx,
   input  logic            ld_modr,
   input  logic [SELW-1:0] ld_sel,
   input  logic [AW-1:0]   ld_val,
   output logic [AW-1:0]   ea
);
   logic [AW-1:0] idx_q [NREG];
   logic [AW-1:0] mod_q [NREG];

   assign ea = idx_q[isel];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < NREG; k++) begin
            idx_q[k] <= '0;
            mod_q[k] <= '0;
         end
      end else begin
         if (commit)
            idx_q[isel] <= idx_q[isel] + mod_q[msel];
         if (ld_idx)
            idx_q[ld_sel] <= ld_val;
         if (ld_modr)
            mod_q[ld_sel] <= ld_val;
      end
   end
endmodule

// File: rtl/asc_bank_sel.sv
module asc_bank_sel #(
   parameter bit DUAL_BLOCK = 1'b1
) (
   input  logic dm_en,
   input  logic pm_en,
   input  logic dm_blk,
   input  logic pm_blk,
   output logic collide
);
   generate
      if (DUAL_BLOCK) begin : g_two
         assign collide = dm_en & pm_en & (dm_blk == pm_blk);
      end else begin : g_one
         logic unused_blk;
         assign unused_blk = dm_blk ^ pm_blk;
         assign collide    = dm_en & pm_en;
      end
   endgenerate
endmodule

// File: rtl/asc_seq.sv
module asc_seq
   import asc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic dm_en,
   input  logic pm_en,
   input  logic collide,
   input  logic g2_load,
   output logic dm_go,
   output logic pm_go,
   output logic accept,
   output logic stall
);
   asc_phase_e phase_q, phase_d;
   logic       haz_q;

   always_comb begin
      dm_go   = 1'b0;
      pm_go   = 1'b0;
      accept  = 1'b0;
      stall   = 1'b0;
      phase_d = PH_MAIN;
      if (phase_q == PH_SECOND) begin
         pm_go  = 1'b1;
         accept = 1'b1;
      end else if (in_valid) begin
         if (haz_q && pm_en) begin
            stall = 1'b1;
         end else if (collide) begin
            dm_go   = 1'b1;
            stall   = 1'b1;
            phase_d = PH_SECOND;
         end else begin
            dm_go  = dm_en;
            pm_go  = pm_en;
            accept = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_MAIN;
         haz_q   <= 1'b0;
      end else begin
         phase_q <= phase_d;
         haz_q   <= accept & g2_load;
      end
   end
endmodule

// File: rtl/dual_bank_stall_ctl.sv
module dual_bank_stall_ctl #(
   parameter int AW      = 24,
   parameter int NREG    = 8,
   parameter int BLK_BIT = 17,
   parameter int SELW    = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic            dm_en,
   input  logic [SELW-1:0] dm_isel,
   input  logic [SELW-1:0] dm_msel,
   input  logic            pm_en,
   input  logic [SELW-1:0] pm_isel,
   input  logic [SELW-1:0] pm_msel,
   input  logic            ld_en,
   input  logic            ld_gen,
   input  logic            ld_mod,
   input  logic [SELW-1:0] ld_sel,
   input  logic [AW-1:0]   ld_val,
   output logic            dm_go,
   output logic [AW-1:0]   dm_addr,
   output logic            pm_go,
   output logic [AW-1:0]   pm_addr,
   output logic            stall
);
   localparam int NGEN = 2;

   generate
      if (BLK_BIT >= AW || BLK_BIT < 0) begin : g_bad_blk
         $error("BLK_BIT must address a bit of the word address");
      end
      if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
         $error("NREG must be a power of two of at least 2");
      end
      if (SELW != $clog2(NREG)) begin : g_bad_selw
         $error("SELW must match NREG");
      end
   endgenerate

   logic [SELW-1:0] isel_a   [NGEN];
   logic [SELW-1:0] msel_a   [NGEN];
   logic            commit_a [NGEN];
   logic [AW-1:0]   ea_a     [NGEN];
   logic            collide;
   logic            accept;

   assign isel_a[0]   = dm_isel;
   assign msel_a[0]   = dm_msel;
   assign isel_a[1]   = pm_isel;
   assign msel_a[1]   = pm_msel;
   assign commit_a[0] = dm_go;
   assign commit_a[1] = pm_go;

   generate
      for (genvar g = 0; g < NGEN; g++) begin : g_gen
         logic ld_hit;
         assign ld_hit = accept & ld_en & (ld_gen == g[0]);
         asc_addr_gen #(
            .AW   (AW),
            .NREG (NREG),
            .SELW (SELW)
         ) gen_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .isel    (isel_a[g]),
            .msel    (msel_a[g]),
            .commit  (commit_a[g]),
            .ld_idx  (ld_hit & ~ld_mod),
            .ld_modr (ld_hit & ld_mod),
            .ld_sel  (ld_sel),
            .ld_val  (ld_val),
            .ea      (ea_a[g])
         );
      end
   endgenerate

   assign dm_addr = ea_a[0];
   assign pm_addr = ea_a[1];

   asc_bank_sel #(
      .DUAL_BLOCK (1'b1)
   ) bank_i (
      .dm_en   (dm_en),
      .pm_en   (pm_en),
      .dm_blk  (ea_a[0][BLK_BIT]),
      .pm_blk  (ea_a[1][BLK_BIT]),
      .collide (collide)
   );

   asc_seq seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .dm_en    (dm_en),
      .pm_en    (pm_en),
      .collide  (collide),
      .g2_load  (ld_en & ld_gen & ~ld_mod),
      .dm_go    (dm_go),
      .pm_go    (pm_go),
      .accept   (accept),
      .stall    (stall)
   );

   assign in_ready = accept;
endmodule

// File: rtl/dual_bank_stall_ctl_chk.sv
module dual_bank_stall_ctl_chk (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_ready,
   input logic dm_en,
   input logic pm_en,
   input logic ld_en,
   input logic ld_gen,
   input logic ld_mod,
   input logic dm_go,
   input logic pm_go,
   input logic dm_blk,
   input logic pm_blk,
   input logic stall
);
   // R3
   split_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dm_go && !pm_go && stall) |=> (pm_go && !dm_go && !stall && in_ready));

   // R1
   dual_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dm_go && pm_go) |-> (dm_blk != pm_blk));

   // R2
   stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> !in_ready);

   // R6
   g2_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && ld_en && ld_gen && !ld_mod) |=> !pm_go);

   // R5
   dm_slot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !dm_en) |-> !dm_go);

   // R5
   pm_slot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !pm_en) |-> !pm_go);

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> (!dm_go && !pm_go && !in_ready && !stall));
endmodule

bind dual_bank_stall_ctl dual_bank_stall_ctl_chk chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .dm_en    (dm_en),
   .pm_en    (pm_en),
   .ld_en    (ld_en),
   .ld_gen   (ld_gen),
   .ld_mod   (ld_mod),
   .dm_go    (dm_go),
   .pm_go    (pm_go),
   .dm_blk   (dm_addr[BLK_BIT]),
   .pm_blk   (pm_addr[BLK_BIT]),
   .stall    (stall)
);

// File: tb/dual_bank_stall_ctl_tb_top.sv
module dual_bank_stall_ctl_tb_top;
   localparam int AWT  = 24;
   localparam int BBIT = 17;
   localparam int MASK = 24'hFFFFFF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic dm_en = 1'b0, pm_en = 1'b0;
   logic [2:0] dm_isel = '0, dm_msel = '0, pm_isel = '0, pm_msel = '0;
   logic ld_en = 1'b0, ld_gen = 1'b0, ld_mod = 1'b0;
   logic [2:0] ld_sel = '0;
   logic [AWT-1:0] ld_val = '0;
   logic dm_go, pm_go, stall;
   logic [AWT-1:0] dm_addr, pm_addr;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   int m_idx [2][8];
   int m_mod [2][8];
   bit m_phb = 1'b0;
   bit m_haz = 1'b0;

   always #10 clk = ~clk;

   dual_bank_stall_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .dm_en(dm_en), .dm_isel(dm_isel), .dm_msel(dm_msel),
      .pm_en(pm_en), .pm_isel(pm_isel), .pm_msel(pm_msel),
      .ld_en(ld_en), .ld_gen(ld_gen), .ld_mod(ld_mod), .ld_sel(ld_sel), .ld_val(ld_val),
      .dm_go(dm_go), .dm_addr(dm_addr), .pm_go(pm_go), .pm_addr(pm_addr), .stall(stall)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int blk_of(input int a);
      return (a >> BBIT) & 1;
   endfunction

   // One clock cycle: compare outputs with the model, then advance the model.
   task automatic step(output bit acc);
      bit e_dm, e_pm, e_acc, e_st;
      #1;
      e_dm = 0; e_pm = 0; e_acc = 0; e_st = 0;
      if (m_phb) begin
         e_pm = 1; e_acc = 1;
      end else if (in_valid) begin
         if (m_haz && pm_en) e_st = 1;
         else if (dm_en && pm_en &&
                  blk_of(m_idx[0][dm_isel]) == blk_of(m_idx[1][pm_isel])) begin
            e_dm = 1; e_st = 1;
         end else begin
            e_dm = dm_en; e_pm = pm_en; e_acc = 1;
         end
      end
      chk(dm_go === e_dm, "R3", "dm_go", int'(dm_go), int'(e_dm));
      chk(pm_go === e_pm, "R2", "pm_go", int'(pm_go), int'(e_pm));
      chk(stall === e_st, "R6", "stall", int'(stall), int'(e_st));
      chk(in_ready === e_acc, "R10", "in_ready", int'(in_ready), int'(e_acc));
      if (e_dm) chk(int'(dm_addr) == m_idx[0][dm_isel], "R4", "dm_addr",
                    int'(dm_addr), m_idx[0][dm_isel]);
      if (e_pm) chk(int'(pm_addr) == m_idx[1][pm_isel], "R4", "pm_addr",
                    int'(pm_addr), m_idx[1][pm_isel]);
      @(posedge clk);
      if (e_dm) m_idx[0][dm_isel] = (m_idx[0][dm_isel] + m_mod[0][dm_msel]) & MASK;
      if (e_pm) m_idx[1][pm_isel] = (m_idx[1][pm_isel] + m_mod[1][pm_msel]) & MASK;
      if (e_acc && ld_en) begin
         if (ld_mod) m_mod[ld_gen][ld_sel] = int'(ld_val);
         else        m_idx[ld_gen][ld_sel] = int'(ld_val);
      end
      m_haz = e_acc && ld_en && ld_gen && !ld_mod;
      m_phb = !m_phb && e_dm && e_st;
      @(negedge clk);
      acc = e_acc;
   endtask

   task automatic issue(input bit de, input int di, input int dmo,
                        input bit pe, input int pi, input int pmo,
                        input bit le, input bit lg, input bit lm, input int ls,
                        input int lv, output int cyc);
      bit acc;
      in_valid = 1; dm_en = de; dm_isel = 3'(di); dm_msel = 3'(dmo);
      pm_en = pe; pm_isel = 3'(pi); pm_msel = 3'(pmo);
      ld_en = le; ld_gen = lg; ld_mod = lm; ld_sel = 3'(ls); ld_val = AWT'(lv);
      cyc = 0;
      do begin
         step(acc);
         cyc++;
      end while (!acc && cyc < 8);
      in_valid = 0; ld_en = 0;
   endtask

   task automatic idle();
      bit acc;
      in_valid = 0; dm_en = 0; pm_en = 0; ld_en = 0;
      step(acc);
   endtask

   task automatic load(input bit g, input bit m, input int s, input int v);
      int c;
      issue(0, 0, 0, 0, 0, 0, 1, g, m, s, v, c);
   endtask

   initial begin
      int c;
      for (int g = 0; g < 2; g++)
         for (int k = 0; k < 8; k++) begin
            m_idx[g][k] = 0; m_mod[g][k] = 0;
         end
      repeat (3) @(negedge clk);
      // R9: outputs quiet while reset is held
      chk(stall === 0 && dm_go === 0 && pm_go === 0 && in_ready === 0, "R9",
          "reset outputs", int'({stall, dm_go, pm_go, in_ready}), 0);
      rst_n = 1;
      @(negedge clk);
      // R9: registers start at zero
      issue(1, 2, 0, 1, 2, 0, 0, 0, 0, 0, 0, c);
      chk(c == 2, "R9", "zero regs collide cycles", c, 2);

      load(0, 0, 1, 'h00100);
      load(0, 1, 2, 4);
      load(1, 1, 3, 1);
      load(1, 0, 5, 'h20010);
      idle();                                    // R7: idle hides bubble
      issue(1, 1, 2, 1, 5, 3, 0, 0, 0, 0, 0, c);
      chk(c == 1, "R2", "split blocks cycles", c, 1);
      issue(1, 1, 2, 1, 5, 3, 0, 0, 0, 0, 0, c);  // R4: post-modified addresses
      chk(c == 1, "R4", "second pass cycles", c, 1);

      load(0, 0, 1, 'h20000);
      issue(1, 1, 2, 1, 5, 3, 0, 0, 0, 0, 0, c);
      chk(c == 2, "R3", "same block cycles", c, 2);

      load(1, 0, 5, 'h30000);
      issue(0, 0, 0, 1, 5, 3, 0, 0, 0, 0, 0, c);
      chk(c == 2, "R6", "pm use after g2 load", c, 2);

      load(1, 0, 5, 'h00040);
      issue(1, 1, 2, 0, 5, 3, 0, 0, 0, 0, 0, c);
      chk(c == 1, "R7", "dm-only between", c, 1);
      issue(1, 1, 2, 1, 5, 3, 0, 0, 0, 0, 0, c);
      chk(c == 1, "R7", "hidden bubble", c, 1);

      load(1, 0, 5, 'h20050);
      issue(1, 1, 2, 1, 5, 3, 0, 0, 0, 0, 0, c);
      chk(c == 3, "R6", "bubble then split", c, 3);

      load(0, 0, 2, 'h00100);
      issue(0, 0, 0, 1, 5, 3, 0, 0, 0, 0, 0, c);
      chk(c == 1, "R7", "dm-side load no bubble", c, 1);

      // R5: disabled pm slot points into the same block
      issue(1, 1, 2, 0, 5, 3, 0, 0, 0, 0, 0, c);
      chk(c == 1, "R5", "disabled slot no collide", c, 1);
      issue(0, 0, 0, 1, 5, 3, 0, 0, 0, 0, 0, c);
      chk(c == 1, "R5", "pm index untouched", c, 1);

      // R8: load beats post-modify on the same register
      issue(1, 1, 2, 0, 0, 0, 1, 0, 0, 1, 'h01234, c);
      issue(1, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0, c);
      chk(c == 1, "R8", "load priority issue", c, 1);

      // R1: block boundary at 0x20000
      load(0, 0, 3, 'h1FFFF);
      load(0, 1, 4, 1);
      load(1, 0, 6, 0);
      idle();
      issue(1, 3, 4, 1, 6, 0, 0, 0, 0, 0, 0, c);
      chk(c == 2, "R1", "0x1FFFF vs 0 cycles", c, 2);
      issue(1, 3, 4, 1, 6, 0, 0, 0, 0, 0, 0, c);
      chk(c == 1, "R1", "0x20000 vs 0 cycles", c, 1);

      // R4: wrap at 2^24
      load(0, 0, 7, 'hFFFFFF);
      issue(1, 7, 4, 0, 0, 0, 0, 0, 0, 0, 0, c);
      issue(1, 7, 4, 0, 0, 0, 0, 0, 0, 0, 0, c);

      // R10: idle cycles
      idle();
      idle();

      for (int n = 0; n < 400; n++) begin
         if ($urandom_range(0, 5) == 0) idle();
         issue(1'($urandom_range(0, 1)), $urandom_range(0, 7), $urandom_range(0, 7),
               1'($urandom_range(0, 1)), $urandom_range(0, 7), $urandom_range(0, 7),
               1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 3) == 0), $urandom_range(0, 7),
               ($urandom_range(0, 1) << 17) | $urandom_range(0, 'hFF), c);
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule